// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block gathers the interrupt sources that belong to each core of a small multi-core cluster and drives one normal-priority (IRQ) line and one fast (FIQ) line into every core. Each core owns four timer inputs, four mailbox inputs and a performance-monitor input. One shared external interrupt arrives as a normal request and a fast request, and each of the two is steered to a single core chosen by software.

Software programs the block over a simple word-addressed register bus. Every core has one byte of timer enables and one byte of mailbox enables. The low nibble of each byte selects the IRQ path and the high nibble selects the FIQ path. When both are set, the FIQ path wins. The performance-monitor enables are changed only through a write-ones-to-set port and a write-ones-to-clear port. Each core can read back which sources are currently asserting its IRQ line and which are asserting its FIQ line. Sources are acknowledged at their origin. The block holds only enables and steering, and the pending words follow the inputs with no storage.

Top module: `core_irq_router`

## Requirements
- R1: While reset is asserted and after it is released, all enables are zero, both shared-interrupt targets are core 0, every irq_out and fiq_out bit is low with all sources idle, and reads of 0x0C and 0x10 return zero.
- R2: The timer control byte of core c is at 0x40 + 4c. Bit k (k = 0..3) enables timer input k of that core onto IRQ. When set, with the FIQ bit clear, an asserted timer line sets bit k of the IRQ pending word at 0x60 + 4c and raises irq_out[c].
- R3: Bit 4+k of a control byte enables the same source onto FIQ and overrides bit k. The source then shows only in the FIQ pending word at 0x70 + 4c (bits 0..7) and raises fiq_out[c], and it never shows in the IRQ word.
- R4: The mailbox control byte of core c is at 0x50 + 4c with the same IRQ/FIQ nibble layout. Mailbox input k of core c appears at pending bit 4+k.
- R5: The steering register at 0x0C holds the IRQ target core in bits [1:0] and the FIQ target core in bits [3:2]. The shared IRQ request sets bit 8 of the target core's IRQ word, and the shared FIQ request sets bit 8 of the target core's FIQ word.
- R6: Writing to 0x10 sets the performance-monitor enable of every core whose bit in [3:0] is 1. Zero bits leave their enable unchanged. Reading 0x10 returns the 4-bit enable mask.
- R7: Writing to 0x14 clears the enable of every core whose bit in [3:0] is 1 and leaves the others unchanged. Reading 0x14 returns zero.
- R8: An enabled, asserted performance-monitor input of core c sets bit 9 of that core's IRQ pending word only. Bit 9 of a FIQ word is always 0.
- R9: irq_out[c] is the OR of core c's IRQ pending word, and fiq_out[c] is the OR of its FIQ pending word.
- R10: Control bytes read back in bits [7:0] with upper bits zero. Writes to pending-word addresses, to unmapped addresses or to misaligned addresses change nothing, and reads of them return zero (pending words excepted).
- R11: Pending words and outputs follow source inputs in the same cycle. A register write takes effect from the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W (8) | Byte address of the accessed word |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr |
| timer_in | input | NUM_CORES*4 | Timer lines, core c owns bits [4c+3:4c] |
| mbox_in | input | NUM_CORES*4 | Mailbox lines, core c owns bits [4c+3:4c] |
| shared_irq_in | input | 1 | Shared external normal-priority request |
| shared_fiq_in | input | 1 | Shared external fast request |
| pmu_in | input | NUM_CORES | Performance-monitor line per core |
| irq_out | output | NUM_CORES | IRQ line per core |
| fiq_out | output | NUM_CORES | FIQ line per core |

## Verification
The bench builds the block with NUM_CORES = 4, which fills every per-core slot the address map provides. It also makes both 2-bit steering fields fully meaningful, so the shared requests can be sent to core 3 and the two fields can point at different cores. With this width every control, pending and set/clear bit is live, so a random mix of writes, reads across all decoded and several unmapped or misaligned addresses, and source patterns reaches each FIQ-over-IRQ collision on every core.

// File: rtl/cir_pkg.sv
package cir_pkg;
    // Register byte offsets; per-core banks use a 4-byte stride.
    localparam int OFS_STEER    = 'h0C;
    localparam int OFS_PMU_SET  = 'h10;
    localparam int OFS_PMU_CLR  = 'h14;
    localparam int OFS_TMR_BASE = 'h40;
    localparam int OFS_MBX_BASE = 'h50;
    localparam int OFS_IRQ_BASE = 'h60;
    localparam int OFS_FIQ_BASE = 'h70;

    localparam int GRP     = 4;          // sources per timer / mailbox group
    localparam int CTL_W   = 2 * GRP;    // IRQ nibble + FIQ nibble
    localparam int PEND_W  = 10;
    localparam int BIT_TMR = 0;
    localparam int BIT_MBX = GRP;
    localparam int BIT_SHR = 2 * GRP;
    localparam int BIT_PMU = 2 * GRP + 1;
endpackage

// File: rtl/cir_regs.sv
module cir_regs
    import cir_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CW        = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NUM_CORES*CTL_W-1:0]   tmr_ctl_o,
    output logic [NUM_CORES*CTL_W-1:0]   mbx_ctl_o,
    output logic [2*CW-1:0]              steer_o,
    output logic [NUM_CORES-1:0]         pmu_en_o
);
    typedef struct packed {
        logic [NUM_CORES-1:0][CTL_W-1:0] tmr;
        logic [NUM_CORES-1:0][CTL_W-1:0] mbx;
        logic [2*CW-1:0]                 steer;
        logic [NUM_CORES-1:0]            pmu;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (addr == ADDR_W'(OFS_STEER))
                st_d.steer = wdata[2*CW-1:0];
            if (addr == ADDR_W'(OFS_PMU_SET))
                st_d.pmu = st_q.pmu | wdata[NUM_CORES-1:0];
            if (addr == ADDR_W'(OFS_PMU_CLR))
                st_d.pmu = st_q.pmu & ~wdata[NUM_CORES-1:0];
            for (int c = 0; c < NUM_CORES; c++) begin
                if (addr == ADDR_W'(OFS_TMR_BASE + 4 * c))
                    st_d.tmr[c] = wdata[CTL_W-1:0];
                if (addr == ADDR_W'(OFS_MBX_BASE + 4 * c))
                    st_d.mbx[c] = wdata[CTL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmr_ctl_o = st_q.tmr;
    assign mbx_ctl_o = st_q.mbx;
    assign steer_o   = st_q.steer;
    assign pmu_en_o  = st_q.pmu;
endmodule

// File: rtl/cir_core_pend.sv
module cir_core_pend
    import cir_pkg::*;
#(
    parameter int CW      = 2,
    parameter int CORE_ID = 0
) (
    input  logic [CTL_W-1:0]  tmr_ctl,
    input  logic [CTL_W-1:0]  mbx_ctl,
    input  logic [GRP-1:0]    tmr_line,
    input  logic [GRP-1:0]    mbx_line,
    input  logic              shr_irq,
    input  logic              shr_fiq,
    input  logic [CW-1:0]     irq_tgt,
    input  logic [CW-1:0]     fiq_tgt,
    input  logic              pmu_line,
    input  logic              pmu_en,
    output logic [PEND_W-1:0] irq_pend,
    output logic [PEND_W-1:0] fiq_pend,
    output logic              irq,
    output logic              fiq
);
    always_comb begin
        irq_pend = '0;
        fiq_pend = '0;
        for (int k = 0; k < GRP; k++) begin
            // Fast enable takes the source away from the normal path.
            if (tmr_line[k]) begin
                if (tmr_ctl[GRP+k])  fiq_pend[BIT_TMR+k] = 1'b1;
                else if (tmr_ctl[k]) irq_pend[BIT_TMR+k] = 1'b1;
            end
            if (mbx_line[k]) begin
                if (mbx_ctl[GRP+k])  fiq_pend[BIT_MBX+k] = 1'b1;
                else if (mbx_ctl[k]) irq_pend[BIT_MBX+k] = 1'b1;
            end
        end
        irq_pend[BIT_SHR] = shr_irq && (irq_tgt == CW'(CORE_ID));
        fiq_pend[BIT_SHR] = shr_fiq && (fiq_tgt == CW'(CORE_ID));
        irq_pend[BIT_PMU] = pmu_line && pmu_en;
    end

    assign irq = |irq_pend;
    assign fiq = |fiq_pend;
endmodule

// File: rtl/cir_rdmux.sv
module cir_rdmux
    import cir_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CW        = 2
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_CORES*CTL_W-1:0]  tmr_ctl,
    input  logic [NUM_CORES*CTL_W-1:0]  mbx_ctl,
    input  logic [2*CW-1:0]             steer,
    input  logic [NUM_CORES-1:0]        pmu_en,
    input  logic [NUM_CORES*PEND_W-1:0] irq_pend,
    input  logic [NUM_CORES*PEND_W-1:0] fiq_pend,
    output logic [DATA_W-1:0]           rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_STEER))   rdata[2*CW-1:0]    = steer;
        if (addr == ADDR_W'(OFS_PMU_SET)) rdata[NUM_CORES-1:0] = pmu_en;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (addr == ADDR_W'(OFS_TMR_BASE + 4 * c))
                rdata[CTL_W-1:0] = tmr_ctl[c*CTL_W +: CTL_W];
            if (addr == ADDR_W'(OFS_MBX_BASE + 4 * c))
                rdata[CTL_W-1:0] = mbx_ctl[c*CTL_W +: CTL_W];
            if (addr == ADDR_W'(OFS_IRQ_BASE + 4 * c))
                rdata[PEND_W-1:0] = irq_pend[c*PEND_W +: PEND_W];
            if (addr == ADDR_W'(OFS_FIQ_BASE + 4 * c))
                rdata[PEND_W-1:0] = fiq_pend[c*PEND_W +: PEND_W];
        end
    end
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
    import cir_pkg::*;
#(
    parameter int NUM_CORES = 4,   // 1..4, bounded by the 4-slot banks
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [NUM_CORES*GRP-1:0] timer_in,
    input  logic [NUM_CORES*GRP-1:0] mbox_in,
    input  logic                     shared_irq_in,
    input  logic                     shared_fiq_in,
    input  logic [NUM_CORES-1:0]     pmu_in,
    output logic [NUM_CORES-1:0]     irq_out,
    output logic [NUM_CORES-1:0]     fiq_out
);
    localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic [NUM_CORES*CTL_W-1:0]  tmr_ctl;
    logic [NUM_CORES*CTL_W-1:0]  mbx_ctl;
    logic [2*CW-1:0]             steer;
    logic [NUM_CORES-1:0]        pmu_en;
    logic [NUM_CORES*PEND_W-1:0] irq_pend_all;
    logic [NUM_CORES*PEND_W-1:0] fiq_pend_all;

    cir_regs #(
        .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .tmr_ctl_o(tmr_ctl), .mbx_ctl_o(mbx_ctl),
        .steer_o(steer), .pmu_en_o(pmu_en)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        cir_core_pend #(.CW(CW), .CORE_ID(c)) pend_i (
            .tmr_ctl (tmr_ctl[c*CTL_W +: CTL_W]),
            .mbx_ctl (mbx_ctl[c*CTL_W +: CTL_W]),
            .tmr_line(timer_in[c*GRP +: GRP]),
            .mbx_line(mbox_in[c*GRP +: GRP]),
            .shr_irq (shared_irq_in),
            .shr_fiq (shared_fiq_in),
            .irq_tgt (steer[CW-1:0]),
            .fiq_tgt (steer[2*CW-1:CW]),
            .pmu_line(pmu_in[c]),
            .pmu_en  (pmu_en[c]),
            .irq_pend(irq_pend_all[c*PEND_W +: PEND_W]),
            .fiq_pend(fiq_pend_all[c*PEND_W +: PEND_W]),
            .irq     (irq_out[c]),
            .fiq     (fiq_out[c])
        );
    end

    cir_rdmux #(
        .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW)
    ) rdmux_i (
        .addr(reg_addr), .tmr_ctl(tmr_ctl), .mbx_ctl(mbx_ctl), .steer(steer),
        .pmu_en(pmu_en), .irq_pend(irq_pend_all), .fiq_pend(fiq_pend_all),
        .rdata(reg_rdata)
    );
endmodule

// File: rtl/cir_chk.sv
module cir_chk
    import cir_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CW        = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_we,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [DATA_W-1:0]           reg_wdata,
    input logic                        shared_fiq_in,
    input logic [NUM_CORES-1:0]        fiq_out,
    input logic [2*CW-1:0]             steer,
    input logic [NUM_CORES-1:0]        pmu_en,
    input logic [NUM_CORES*PEND_W-1:0] irq_pend_all,
    input logic [NUM_CORES*PEND_W-1:0] fiq_pend_all
);
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        // R3
        irq_fiq_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_pend_all[c*PEND_W +: CTL_W] & fiq_pend_all[c*PEND_W +: CTL_W]) == '0);

        // R6
        pmu_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == ADDR_W'(OFS_PMU_SET) && reg_wdata[c]) |=> pmu_en[c]);

        // R6
        pmu_zero_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == ADDR_W'(OFS_PMU_SET) && !reg_wdata[c]) |=> $stable(pmu_en[c]));

        // R7
        pmu_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == ADDR_W'(OFS_PMU_CLR) && reg_wdata[c]) |=> !pmu_en[c]);

        // R5
        shared_fiq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (shared_fiq_in && steer[2*CW-1:CW] == CW'(c)) |-> fiq_out[c]);
    end
endmodule

bind core_irq_router cir_chk #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .shared_fiq_in(shared_fiq_in), .fiq_out(fiq_out),
    .steer(steer), .pmu_en(pmu_en), .irq_pend_all(irq_pend_all),
    .fiq_pend_all(fiq_pend_all)
);

// File: tb/core_irq_router_tb_top.sv
module core_irq_router_tb_top;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [15:0] timer_in;
    logic [15:0] mbox_in;
    logic        shared_irq_in;
    logic        shared_fiq_in;
    logic [3:0]  pmu_in;
    logic [3:0]  irq_out;
    logic [3:0]  fiq_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state
    logic [7:0] m_tmr [NC];
    logic [7:0] m_mbx [NC];
    logic [3:0] m_steer;
    logic [3:0] m_pmu;

    always #4 clk = ~clk;   // 125 MHz

    core_irq_router dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_in(timer_in),
        .mbox_in(mbox_in), .shared_irq_in(shared_irq_in),
        .shared_fiq_in(shared_fiq_in), .pmu_in(pmu_in),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    function automatic logic [9:0] m_pend(int c, bit fast);
        logic [9:0] r;
        r = '0;
        for (int k = 0; k < 4; k++) begin
            if (timer_in[c*4+k]) begin
                if (fast) r[k] = m_tmr[c][4+k];
                else      r[k] = m_tmr[c][k] && !m_tmr[c][4+k];
            end
            if (mbox_in[c*4+k]) begin
                if (fast) r[4+k] = m_mbx[c][4+k];
                else      r[4+k] = m_mbx[c][k] && !m_mbx[c][4+k];
            end
        end
        if (fast) r[8] = shared_fiq_in && (int'(m_steer[3:2]) == c);
        else begin
            r[8] = shared_irq_in && (int'(m_steer[1:0]) == c);
            r[9] = pmu_in[c] && m_pmu[c];
        end
        return r;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        int c;
        c = int'(a[3:2]);
        if (a == 8'h0C) return {28'd0, m_steer};
        if (a == 8'h10) return {28'd0, m_pmu};
        if (a[1:0] != 2'b00) return 32'd0;
        case (a[7:4])
            4'h4: return {24'd0, m_tmr[c]};
            4'h5: return {24'd0, m_mbx[c]};
            4'h6: return {22'd0, m_pend(c, 1'b0)};
            4'h7: return {22'd0, m_pend(c, 1'b1)};
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_write(logic [7:0] a, logic [31:0] d);
        int c;
        c = int'(a[3:2]);
        if (a == 8'h0C) m_steer = d[3:0];
        else if (a == 8'h10) m_pmu = m_pmu | d[3:0];
        else if (a == 8'h14) m_pmu = m_pmu & ~d[3:0];
        else if (a[1:0] == 2'b00 && a[7:4] == 4'h4) m_tmr[c] = d[7:0];
        else if (a[1:0] == 2'b00 && a[7:4] == 4'h5) m_mbx[c] = d[7:0];
    endtask

    task automatic compare(string tag);
        logic [3:0]  ei, ef;
        logic [31:0] er;
        for (int c = 0; c < NC; c++) begin
            ei[c] = |m_pend(c, 1'b0);
            ef[c] = |m_pend(c, 1'b1);
        end
        er = m_read(reg_addr);
        n_vec++;
        if (irq_out !== ei || fiq_out !== ef || reg_rdata !== er) begin
            n_fail++;
            $display("FAIL %s addr=%h: irq=%h fiq=%h rd=%h expected irq=%h fiq=%h rd=%h",
                     tag, reg_addr, irq_out, fiq_out, reg_rdata, ei, ef, er);
        end
    endtask

    task automatic step(string tag, logic we, logic [7:0] a, logic [31:0] d,
                        logic [15:0] tm, logic [15:0] mb, logic si, logic sf,
                        logic [3:0] pm);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d;
        timer_in = tm; mbox_in = mb; shared_irq_in = si; shared_fiq_in = sf;
        pmu_in = pm;
        #1;
        compare(tag);
        @(posedge clk);
        if (we) m_write(a, d);
    endtask

    task automatic rd(string tag, logic [7:0] a, logic [15:0] tm, logic [15:0] mb,
                      logic si, logic sf, logic [3:0] pm);
        step(tag, 1'b0, a, 32'd0, tm, mb, si, sf, pm);
    endtask

    task automatic wr(string tag, logic [7:0] a, logic [31:0] d);
        step(tag, 1'b1, a, d, 16'd0, 16'd0, 1'b0, 1'b0, 4'd0);
    endtask

    function automatic logic [7:0] pick_addr(int s);
        if (s < 4)  return 8'(8'h40 + 4*s);
        if (s < 8)  return 8'(8'h50 + 4*(s-4));
        if (s < 12) return 8'(8'h60 + 4*(s-8));
        if (s < 16) return 8'(8'h70 + 4*(s-12));
        case (s)
            16: return 8'h0C;
            17: return 8'h10;
            18: return 8'h14;
            19: return 8'h00;
            20: return 8'h20;
            21: return 8'h3C;
            22: return 8'h80;
            default: return 8'h41;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin m_tmr[c] = '0; m_mbx[c] = '0; end
        m_steer = '0; m_pmu = '0;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 8'h0C; reg_wdata = '0;
        timer_in = '0; mbox_in = '0; shared_irq_in = 1'b0; shared_fiq_in = 1'b0;
        pmu_in = '0;
        repeat (3) @(posedge clk);
        // R1: reset state seen while reset is held
        @(negedge clk); #1; compare("R1 in reset");
        reg_addr = 8'h10; #1; compare("R1 in reset pmu");
        @(negedge clk); rst_n = 1'b1;
        rd("R1 after reset", 8'h0C, 16'd0, 16'd0, 1'b0, 1'b0, 4'd0);
        rd("R1 pmu after reset", 8'h10, 16'd0, 16'd0, 1'b0, 1'b0, 4'hF);

        // R2: core 1 timer IRQ enables
        wr("R2", 8'h44, 32'h0000_000F);
        rd("R2 pending", 8'h64, 16'h0040, 16'd0, 1'b0, 1'b0, 4'd0);
        rd("R2 readback", 8'h44, 16'h0040, 16'd0, 1'b0, 1'b0, 4'd0);
        // R3: fast enable overrides normal enable on timer 2 of core 1
        wr("R3", 8'h44, 32'h0000_004F);
        rd("R3 irq word", 8'h64, 16'h0040, 16'd0, 1'b0, 1'b0, 4'd0);
        rd("R3 fiq word", 8'h74, 16'h0040, 16'd0, 1'b0, 1'b0, 4'd0);
        // R4: mailbox of core 3
        wr("R4", 8'h5C, 32'h0000_0081);
        rd("R4 irq word", 8'h6C, 16'd0, 16'h9000, 1'b0, 1'b0, 4'd0);
        rd("R4 fiq word", 8'h7C, 16'd0, 16'hF000, 1'b0, 1'b0, 4'd0);
        // R5: shared requests steered, IRQ to core 3, FIQ to core 2
        wr("R5", 8'h0C, 32'h0000_000B);
        rd("R5 steer readback", 8'h0C, 16'd0, 16'd0, 1'b1, 1'b1, 4'd0);
        rd("R5 irq target", 8'h6C, 16'd0, 16'd0, 1'b1, 1'b0, 4'd0);
        rd("R5 fiq target", 8'h78, 16'd0, 16'd0, 1'b0, 1'b1, 4'd0);
        rd("R5 other core", 8'h60, 16'd0, 16'd0, 1'b1, 1'b1, 4'd0);
        // R6 / R7: set and clear of monitor enables
        wr("R6", 8'h10, 32'h0000_0005);
        rd("R6 mask", 8'h10, 16'd0, 16'd0, 1'b0, 1'b0, 4'd0);
        wr("R6 zero bits", 8'h10, 32'h0000_0002);
        rd("R6 mask merged", 8'h10, 16'd0, 16'd0, 1'b0, 1'b0, 4'd0);
        wr("R7", 8'h14, 32'h0000_0004);
        rd("R7 mask", 8'h10, 16'd0, 16'd0, 1'b0, 1'b0, 4'd0);
        rd("R7 clear port reads zero", 8'h14, 16'd0, 16'd0, 1'b0, 1'b0, 4'd0);
        // R8: monitor bit only in the normal word
        rd("R8 irq word", 8'h60, 16'd0, 16'd0, 1'b0, 1'b0, 4'hF);
        rd("R8 fiq word", 8'h70, 16'd0, 16'd0, 1'b0, 1'b0, 4'hF);
        rd("R8 disabled core", 8'h68, 16'd0, 16'd0, 1'b0, 1'b0, 4'hF);
        // R10: writes to pending / unmapped / misaligned are ignored
        step("R10 write pending", 1'b1, 8'h60, 32'hFFFF_FFFF, 16'd0, 16'd0, 1'b0, 1'b0, 4'd0);
        step("R10 write misaligned", 1'b1, 8'h41, 32'hFFFF_FFFF, 16'd0, 16'd0, 1'b0, 1'b0, 4'd0);
        rd("R10 control intact", 8'h40, 16'h000F, 16'd0, 1'b0, 1'b0, 4'd0);
        wr("R10 wide write", 8'h48, 32'hFFFF_FFFF);
        rd("R10 upper bits zero", 8'h48, 16'd0, 16'd0, 1'b0, 1'b0, 4'd0);
        // R9 / R11: random traffic compared every cycle
        for (int i = 0; i < 4000; i++) begin
            step("R9/R11 random", 1'($urandom % 3 == 0),
                 pick_addr(int'($urandom % 24)), $urandom,
                 16'($urandom & $urandom), 16'($urandom & $urandom),
                 1'($urandom), 1'($urandom), 4'($urandom));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule